// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block owns the DDR2 command bus from reset until the memory is ready for normal traffic. After reset it holds the clock enable low for a programmable settling time. It then raises the clock enable with a NOP and walks the fixed start-up order: precharge all, the four mode-register loads with DLL enable and DLL reset, a second precharge, two refreshes, and the final three loads. The final loads clear DLL reset, set the driver calibration to its default, and then leave calibration. Each command is followed by its own minimum wait, counted in clock cycles by one shared down-counter.

The mode-register words come from configuration inputs. The base mode-register word and the two auxiliary extended words are supplied whole. The main extended word is assembled from separate fields: drive strength, termination value, additive latency, complementary-strobe disable, read-strobe enable and output disable. When the sequence completes, `init_done` rises. Reads are gated by `read_allowed`, which also waits 200 cycles after the DLL-reset load. The termination pin passes the controller's request only after initialization, and only once eight cycles have gone by since the last extended load that switched termination on.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block drives `ddr_cke` low, `ddr_cs_n` high, `ddr_odt`, `init_done` and `read_allowed` low, and restarts from the power-up wait.
- R2: After reset is released, `ddr_cke` stays low, with `ddr_cs_n` high, for `T_PWRUP` clock edges. On the next edge it rises together with a NOP, and it never falls again until reset.
- R3: Commands use `ddr_cs_n` low with {`ddr_ras_n`,`ddr_cas_n`,`ddr_we_n`} = 111 NOP, 010 precharge, 001 refresh, 000 mode load.
- R4: After the NOP, each command is issued for one cycle, in this order and at these spacings. The NOP is followed after `T_NOP` cycles by precharge. After `T_RPA`, the loads follow: auxiliary word 2, auxiliary word 3, main extended word, then base word with DLL reset, each `T_MRD` apart. Then a precharge comes after `T_MRD`, a refresh after `T_RPA`, a refresh after `T_RFC`, and base word without DLL reset after `T_RFC`. Finally the extended word with calibration default and the extended word with calibration exit come `T_MRD` apart. Every other cycle with `ddr_cke` high is a NOP with bank and address zero.
- R5: Both precharges drive address bit 10 high and all other address and bank bits low. Refreshes drive bank and address zero.
- R6: A mode load selects its register on `ddr_ba` = 0 (base), 1 (main extended), 2 (auxiliary 2), 3 (auxiliary 3); bank bit 2 is always 0.
- R7: The first base-word load drives `cfg_mr` with address bit 8 forced to 1. The second drives `cfg_mr` with bit 8 forced to 0. The auxiliary loads drive `cfg_emr2` and `cfg_emr3` unchanged.
- R8: The main extended word has bit 0 = 0 (DLL on) and bit 1 = `cfg_drive_half`. Bits 2 and 6 are `cfg_rtt[0]` and `cfg_rtt[1]`, and bits 5:3 are `cfg_add_lat`. Bit 10 is `cfg_strobe_n_off`, bit 11 is `cfg_rstrobe_on` and bit 12 is `cfg_out_off`.
- R9: Calibration bits 9:7 of the main extended word are 111 in the calibration-default load and 000 in the other two extended loads.
- R10: `init_done` rises `T_MRD` cycles after the calibration-exit load and then stays high, with the bus idling as NOP, until reset.
- R11: `read_allowed` is high only when `init_done` is high and at least `RD_LOCK` cycles have passed since the DLL-reset load.
- R12: `ddr_odt` equals `odt_req` only when `init_done` is high and, if `cfg_rtt` is nonzero, at least `ODT_HOLD` cycles have passed since the latest extended load that enabled termination; otherwise `ddr_odt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mr | input | 13 | Base mode-register word (bit 8 overridden) |
| cfg_emr2 | input | 13 | Auxiliary extended word 2 |
| cfg_emr3 | input | 13 | Auxiliary extended word 3 |
| cfg_drive_half | input | 1 | Reduced output drive |
| cfg_rtt | input | 2 | Termination select {bit6, bit2} |
| cfg_add_lat | input | 3 | Additive latency field |
| cfg_strobe_n_off | input | 1 | Disable complementary strobe |
| cfg_rstrobe_on | input | 1 | Enable read strobe |
| cfg_out_off | input | 1 | Disable data outputs |
| odt_req | input | 1 | Termination request from controller |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | 13 | Address bus |
| ddr_odt | output | 1 | On-die termination control |
| init_done | output | 1 | Sequence complete |
| read_allowed | output | 1 | Reads may be issued |

## Verification
The bench sweeps every termination setting against several field patterns. One pattern has bit 8 already set in the base word, which catches a design that ORs in the DLL-reset bit but never clears it for the second load. It checks each command's cycle exactly, so an off-by-one in the shared counter shows up as a command issued one cycle early or late. The small parameter set makes the read lockout and the termination hold both end after `init_done`. A design that gated reads or the termination pin on `init_done` alone would therefore assert them several cycles too early. With termination off, the pin must follow the request from `init_done` onward. A reset in the middle of the sequence must drop the clock enable and restart the full power-up wait.

// File: rtl/ddr2i_pkg.sv
// Shared types for the DDR2 initialization sequencer.
// Assumes a single-rank device with 13 address bits and 3 bank bits.
package ddr2i_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP, ST_CKE, ST_PRE1, ST_EMR2, ST_EMR3, ST_EMR_DLL, ST_MR_RST,
        ST_PRE2, ST_REF1, ST_REF2, ST_MR, ST_EMR_OCD, ST_EMR_EXIT, ST_DONE
    } init_st_e;

    localparam logic [2:0] CMD_NOP = 3'b111;
    localparam logic [2:0] CMD_PRE = 3'b010;
    localparam logic [2:0] CMD_REF = 3'b001;
    localparam logic [2:0] CMD_LMR = 3'b000;

    localparam logic [2:0] BA_MR   = 3'd0;
    localparam logic [2:0] BA_EMR  = 3'd1;
    localparam logic [2:0] BA_EMR2 = 3'd2;
    localparam logic [2:0] BA_EMR3 = 3'd3;

    function automatic init_st_e next_st(input init_st_e s);
        case (s)
            ST_PWRUP:    return ST_CKE;
            ST_CKE:      return ST_PRE1;
            ST_PRE1:     return ST_EMR2;
            ST_EMR2:     return ST_EMR3;
            ST_EMR3:     return ST_EMR_DLL;
            ST_EMR_DLL:  return ST_MR_RST;
            ST_MR_RST:   return ST_PRE2;
            ST_PRE2:     return ST_REF1;
            ST_REF1:     return ST_REF2;
            ST_REF2:     return ST_MR;
            ST_MR:       return ST_EMR_OCD;
            ST_EMR_OCD:  return ST_EMR_EXIT;
            default:     return ST_DONE;
        endcase
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2i_wait_ctr.sv
// Down-counter shared by every minimum wait of the sequence.
// Loads a value on request, counts to zero and holds there.
// Assumes RST_VAL fits in CW bits.
module ddr2i_wait_ctr #(
    parameter int CW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= CW'(RST_VAL);
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2i_holdoff.sv
// Hold-off timer: after a start pulse, ok rises once N cycles have passed.
// A new start restarts the window. ok stays low until the first start.
// Assumes N >= 1.
module ddr2i_holdoff #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ok
);
    localparam int HW = $clog2(N + 1);

    logic [HW-1:0] cnt_q;
    logic          armed_q;

    // Track the window opened by the most recent start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= HW'(N - 1);
            armed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign ok = armed_q && (cnt_q == '0) && !start;
endmodule

// File: rtl/ddr2i_mode_words.sv
// Combinational command, bank and address for the step being entered.
// Builds the main extended word from its fields and forces the
// DLL-reset bit of the base word per step.
module ddr2i_mode_words
    import ddr2i_pkg::*;
(
    input  init_st_e    st,
    input  logic [12:0] cfg_mr,
    input  logic [12:0] cfg_emr2,
    input  logic [12:0] cfg_emr3,
    input  logic        cfg_drive_half,
    input  logic [1:0]  cfg_rtt,
    input  logic [2:0]  cfg_add_lat,
    input  logic        cfg_strobe_n_off,
    input  logic        cfg_rstrobe_on,
    input  logic        cfg_out_off,
    output logic [2:0]  cmd,
    output logic [2:0]  ba,
    output logic [12:0] addr
);
    logic [12:0] emr_base;

    // Assemble the main extended word with calibration bits cleared.
    always_comb begin
        emr_base      = '0;
        emr_base[1]   = cfg_drive_half;
        emr_base[2]   = cfg_rtt[0];
        emr_base[5:3] = cfg_add_lat;
        emr_base[6]   = cfg_rtt[1];
        emr_base[10]  = cfg_strobe_n_off;
        emr_base[11]  = cfg_rstrobe_on;
        emr_base[12]  = cfg_out_off;
    end

    // Select the bus values for each step.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        case (st)
            ST_PRE1, ST_PRE2: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
            end
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_EMR2: begin
                cmd = CMD_LMR; ba = BA_EMR2; addr = cfg_emr2;
            end
            ST_EMR3: begin
                cmd = CMD_LMR; ba = BA_EMR3; addr = cfg_emr3;
            end
            ST_EMR_DLL, ST_EMR_EXIT: begin
                cmd = CMD_LMR; ba = BA_EMR; addr = emr_base;
            end
            ST_EMR_OCD: begin
                cmd = CMD_LMR; ba = BA_EMR; addr = emr_base | 13'h0380;
            end
            ST_MR_RST: begin
                cmd = CMD_LMR; ba = BA_MR; addr = cfg_mr | 13'h0100;
            end
            ST_MR: begin
                cmd = CMD_LMR; ba = BA_MR; addr = cfg_mr & ~13'h0100;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Steps through the start-up command order, one command per step, each
// followed by its minimum wait counted by one shared down-counter.
// Gates reads and termination with two hold-off timers.
// Assumes every wait parameter is at least 1 cycle.
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int T_PWRUP  = 50000,
    parameter int T_NOP    = 100,
    parameter int T_RPA    = 4,
    parameter int T_MRD    = 2,
    parameter int T_RFC    = 32,
    parameter int RD_LOCK  = 200,
    parameter int ODT_HOLD = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [12:0] cfg_mr,
    input  logic [12:0] cfg_emr2,
    input  logic [12:0] cfg_emr3,
    input  logic        cfg_drive_half,
    input  logic [1:0]  cfg_rtt,
    input  logic [2:0]  cfg_add_lat,
    input  logic        cfg_strobe_n_off,
    input  logic        cfg_rstrobe_on,
    input  logic        cfg_out_off,
    input  logic        odt_req,
    output logic        ddr_cke,
    output logic        ddr_cs_n,
    output logic        ddr_ras_n,
    output logic        ddr_cas_n,
    output logic        ddr_we_n,
    output logic [2:0]  ddr_ba,
    output logic [12:0] ddr_addr,
    output logic        ddr_odt,
    output logic        init_done,
    output logic        read_allowed
);
    localparam int MAXW = imax(imax(imax(T_PWRUP, T_NOP), imax(T_RPA, T_MRD)), T_RFC);
    localparam int CW   = $clog2(MAXW + 1);

    init_st_e    st_q, st_nxt;
    logic        wait_zero, adv;
    logic [2:0]  mw_cmd, mw_ba;
    logic [12:0] mw_addr;
    logic [2:0]  cmd_q;
    logic        rd_ok, odt_ok, dll_rst_seen, rtt_emr_seen;

    // Minimum wait, in cycles, that follows the command of a step.
    function automatic int wait_of(input init_st_e s);
        case (s)
            ST_PWRUP:         return T_PWRUP;
            ST_CKE:           return T_NOP;
            ST_PRE1, ST_PRE2: return T_RPA;
            ST_REF1, ST_REF2: return T_RFC;
            ST_DONE:          return 1;
            default:          return T_MRD;
        endcase
    endfunction

    assign st_nxt = next_st(st_q);
    assign adv    = wait_zero && (st_q != ST_DONE);

    ddr2i_wait_ctr #(.CW(CW), .RST_VAL(T_PWRUP - 1)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (CW'(wait_of(st_nxt) - 1)),
        .zero     (wait_zero)
    );

    ddr2i_mode_words u_words (
        .st               (st_nxt),
        .cfg_mr           (cfg_mr),
        .cfg_emr2         (cfg_emr2),
        .cfg_emr3         (cfg_emr3),
        .cfg_drive_half   (cfg_drive_half),
        .cfg_rtt          (cfg_rtt),
        .cfg_add_lat      (cfg_add_lat),
        .cfg_strobe_n_off (cfg_strobe_n_off),
        .cfg_rstrobe_on   (cfg_rstrobe_on),
        .cfg_out_off      (cfg_out_off),
        .cmd              (mw_cmd),
        .ba               (mw_ba),
        .addr             (mw_addr)
    );

    // Step register and registered command bus: one command per step, NOP between.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_PWRUP;
            ddr_cke   <= 1'b0;
            ddr_cs_n  <= 1'b1;
            cmd_q     <= CMD_NOP;
            ddr_ba    <= '0;
            ddr_addr  <= '0;
            init_done <= 1'b0;
        end else if (adv) begin
            st_q      <= st_nxt;
            ddr_cke   <= 1'b1;
            ddr_cs_n  <= 1'b0;
            cmd_q     <= mw_cmd;
            ddr_ba    <= mw_ba;
            ddr_addr  <= mw_addr;
            init_done <= (st_nxt == ST_DONE);
        end else begin
            cmd_q     <= CMD_NOP;
            ddr_ba    <= '0;
            ddr_addr  <= '0;
        end
    end

    assign {ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;

    // Events observed on the issued bus that open the two hold-off windows.
    assign dll_rst_seen = !ddr_cs_n && (cmd_q == CMD_LMR) && (ddr_ba == BA_MR) && ddr_addr[8];
    assign rtt_emr_seen = !ddr_cs_n && (cmd_q == CMD_LMR) && (ddr_ba == BA_EMR)
                          && (ddr_addr[6] || ddr_addr[2]);

    ddr2i_holdoff #(.N(RD_LOCK)) u_rd_hold (
        .clk (clk), .rst_n (rst_n), .start (dll_rst_seen), .ok (rd_ok)
    );

    ddr2i_holdoff #(.N(ODT_HOLD)) u_odt_hold (
        .clk (clk), .rst_n (rst_n), .start (rtt_emr_seen), .ok (odt_ok)
    );

    assign read_allowed = init_done && rd_ok;
    assign ddr_odt      = odt_req && init_done && (odt_ok || (cfg_rtt == 2'b00));
endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Property checker for the initialization sequencer, bound to the top.
module ddr2_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ddr_cke,
    input logic ddr_cs_n,
    input logic ddr_ras_n,
    input logic ddr_cas_n,
    input logic ddr_we_n,
    input logic ddr_odt,
    input logic odt_req,
    input logic init_done,
    input logic read_allowed
);
    logic rst_seen_q;

    // Remember that the previous edge applied reset.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Outputs right after a reset edge are in their reset state.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_state: assert (!ddr_cke && ddr_cs_n && !init_done && !read_allowed && !ddr_odt)
                else $error("reset state violated");
        end
    end

    a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    a_r2_no_select_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cke |-> ddr_cs_n);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r10_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n));

    a_r11_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        read_allowed |-> init_done);

    a_r12_odt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_odt |-> (init_done && odt_req));
endmodule

bind ddr2_init_seq ddr2_init_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ddr_cke      (ddr_cke),
    .ddr_cs_n     (ddr_cs_n),
    .ddr_ras_n    (ddr_ras_n),
    .ddr_cas_n    (ddr_cas_n),
    .ddr_we_n     (ddr_we_n),
    .ddr_odt      (ddr_odt),
    .odt_req      (odt_req),
    .init_done    (init_done),
    .read_allowed (read_allowed)
);

// File: tb/ddr2_init_seq_tb.sv
// Sweeps termination settings and field patterns over full init runs,
// checking every command cycle and every gating flag against values
// computed here from the requirements.
module ddr2_init_seq_tb;
    localparam int P_PWR = 20, P_NOP = 5, P_RPA = 3, P_MRD = 2, P_RFC = 6;
    localparam int P_RD = 40, P_ODT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [12:0] cfg_mr = '0, cfg_emr2 = '0, cfg_emr3 = '0;
    logic cfg_drive_half = 1'b0, cfg_strobe_n_off = 1'b0, cfg_rstrobe_on = 1'b0, cfg_out_off = 1'b0;
    logic [1:0] cfg_rtt = '0;
    logic [2:0] cfg_add_lat = '0;
    logic odt_req = 1'b0;
    logic ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_odt, init_done, read_allowed;
    logic [2:0] ddr_ba;
    logic [12:0] ddr_addr;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ddr2_init_seq #(.T_PWRUP(P_PWR), .T_NOP(P_NOP), .T_RPA(P_RPA), .T_MRD(P_MRD),
                    .T_RFC(P_RFC), .RD_LOCK(P_RD), .ODT_HOLD(P_ODT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mr(cfg_mr), .cfg_emr2(cfg_emr2), .cfg_emr3(cfg_emr3),
        .cfg_drive_half(cfg_drive_half), .cfg_rtt(cfg_rtt), .cfg_add_lat(cfg_add_lat),
        .cfg_strobe_n_off(cfg_strobe_n_off), .cfg_rstrobe_on(cfg_rstrobe_on),
        .cfg_out_off(cfg_out_off), .odt_req(odt_req), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
        .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba),
        .ddr_addr(ddr_addr), .ddr_odt(ddr_odt), .init_done(init_done), .read_allowed(read_allowed)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected main extended word, from the bit positions in R8 and R9.
    function automatic logic [12:0] emr_exp(input logic [2:0] ocd);
        int v;
        v = cfg_drive_half * 2 + cfg_rtt[0] * 4 + cfg_add_lat * 8 + cfg_rtt[1] * 64
          + ocd * 128 + cfg_strobe_n_off * 1024 + cfg_rstrobe_on * 2048 + cfg_out_off * 4096;
        return 13'(v);
    endfunction

    int          e_at[12];
    logic [18:0] e_bus[12];  // {cmd, ba, addr}
    string       e_tag[12];

    task automatic build_expect();
        int t;
        int gaps[12];
        gaps = '{0, P_NOP, P_RPA, P_MRD, P_MRD, P_MRD, P_MRD, P_RPA, P_RFC, P_RFC, P_MRD, P_MRD};
        t = P_PWR;
        for (int i = 0; i < 12; i++) begin
            t = t + gaps[i];
            e_at[i] = t;
        end
        e_bus[0]  = {3'b111, 3'd0, 13'h0000};            e_tag[0]  = "R2 R3 nop";
        e_bus[1]  = {3'b010, 3'd0, 13'h0400};            e_tag[1]  = "R3 R5 pre1";
        e_bus[2]  = {3'b000, 3'd2, cfg_emr2};            e_tag[2]  = "R6 R7 emr2";
        e_bus[3]  = {3'b000, 3'd3, cfg_emr3};            e_tag[3]  = "R6 R7 emr3";
        e_bus[4]  = {3'b000, 3'd1, emr_exp(3'b000)};     e_tag[4]  = "R8 R9 emr dll";
        e_bus[5]  = {3'b000, 3'd0, cfg_mr | 13'h0100};   e_tag[5]  = "R7 mr dll reset";
        e_bus[6]  = {3'b010, 3'd0, 13'h0400};            e_tag[6]  = "R5 pre2";
        e_bus[7]  = {3'b001, 3'd0, 13'h0000};            e_tag[7]  = "R3 R5 ref1";
        e_bus[8]  = {3'b001, 3'd0, 13'h0000};            e_tag[8]  = "R4 ref2";
        e_bus[9]  = {3'b000, 3'd0, cfg_mr & ~13'h0100};  e_tag[9]  = "R7 mr no reset";
        e_bus[10] = {3'b000, 3'd1, emr_exp(3'b111)};     e_tag[10] = "R8 R9 emr ocd default";
        e_bus[11] = {3'b000, 3'd1, emr_exp(3'b000)};     e_tag[11] = "R9 emr ocd exit";
    endtask

    task automatic run_one(input int rtt, input int p);
        int done_at, rd_at, odt_at, k;
        int nbad[5];
        logic [31:0] fa[5], fe[5];
        logic [18:0] bus;
        logic exp_b;
        cfg_rtt          = 2'(rtt);
        cfg_drive_half   = p[0];
        cfg_strobe_n_off = p[1];
        cfg_rstrobe_on   = ~p[0];
        cfg_out_off      = p[1] ^ p[0];
        cfg_add_lat      = 3'((p + rtt) % 8);
        cfg_mr           = 13'h0A52 ^ 13'(p << 7);
        cfg_emr2         = 13'h0080 + 13'(p);
        cfg_emr3         = 13'h1000 | 13'(rtt);
        build_expect();
        done_at = e_at[11] + P_MRD;
        rd_at   = (e_at[5] + P_RD > done_at) ? e_at[5] + P_RD : done_at;
        odt_at  = (rtt != 0 && e_at[11] + P_ODT > done_at) ? e_at[11] + P_ODT : done_at;
        for (int i = 0; i < 5; i++) begin nbad[i] = 0; fa[i] = 0; fe[i] = 0; end

        @(negedge clk); rst_n = 1'b0; odt_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!ddr_cke && ddr_cs_n && !init_done && !read_allowed && !ddr_odt, "R1 reset state",
            {ddr_cke, ddr_cs_n, init_done, read_allowed, ddr_odt}, 32'b01000);
        rst_n = 1'b1;
        k = 0;
        for (int cyc = 1; cyc <= done_at + 30; cyc++) begin
            @(negedge clk);
            odt_req = (cyc % 3 != 0);
            #1;
            bus = {ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_ba, ddr_addr};
            if (k < 12 && cyc == e_at[k]) begin
                chk(!ddr_cs_n && bus == e_bus[k], e_tag[k], {ddr_cs_n, bus}, {1'b0, e_bus[k]});
                k++;
            end else if (cyc < P_PWR) begin
                if (!ddr_cs_n && nbad[0]++ == 0) begin fa[0] = cyc; fe[0] = 0; end
            end else if (ddr_cs_n || bus != {3'b111, 16'h0}) begin
                if (nbad[0]++ == 0) begin fa[0] = {ddr_cs_n, bus}; fe[0] = {1'b0, 3'b111, 16'h0}; end
            end
            if (ddr_cke != (cyc >= P_PWR) && nbad[1]++ == 0) begin fa[1] = cyc; fe[1] = P_PWR; end
            if (init_done != (cyc >= done_at) && nbad[2]++ == 0) begin fa[2] = cyc; fe[2] = done_at; end
            if (read_allowed != (cyc >= rd_at) && nbad[3]++ == 0) begin fa[3] = cyc; fe[3] = rd_at; end
            exp_b = odt_req && (cyc >= odt_at);
            if (ddr_odt != exp_b && nbad[4]++ == 0) begin fa[4] = cyc; fe[4] = odt_at; end
        end
        chk(k == 12, "R4 all commands seen", k, 12);
        chk(nbad[0] == 0, "R4 idle cycles are NOP", fa[0], fe[0]);
        chk(nbad[1] == 0, "R2 cke timing", fa[1], fe[1]);
        chk(nbad[2] == 0, "R10 init_done timing", fa[2], fe[2]);
        chk(nbad[3] == 0, "R11 read_allowed timing", fa[3], fe[3]);
        chk(nbad[4] == 0, "R12 odt gating", fa[4], fe[4]);
    endtask

    // A reset mid-sequence must restart the power-up wait.
    task automatic mid_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk(!ddr_cke && ddr_cs_n && !init_done && !read_allowed, "R1 mid-run reset",
            {ddr_cke, ddr_cs_n, init_done, read_allowed}, 32'b0100);
        rst_n = 1'b1;
        repeat (P_PWR - 1) @(negedge clk);
        #1;
        chk(!ddr_cke, "R2 cke low before power-up wait ends", ddr_cke, 0);
        @(negedge clk); #1;
        chk(ddr_cke && !ddr_cs_n, "R2 cke rises after restart", {ddr_cke, ddr_cs_n}, 2'b10);
    endtask

    initial begin
        for (int rtt = 0; rtt < 4; rtt++)
            for (int p = 0; p < 4; p++)
                run_one(rtt, p);
        mid_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule